// File: doc/BRIEF.md
# Fragment-Grid Edge Filter Sequencer

This block walks a rectangular grid of 8x8 fragments in raster order, one row of fragments after another, and decides which edges of each coded fragment need deblocking. For every edge it decides to filter, it issues a command that names the fragment index and the edge side to a downstream edge filter, and it holds that command until the filter accepts it with a ready handshake. It does no pixel arithmetic and computes no pixel addresses.

A run begins with a one-cycle start strobe. The strobe carries the first fragment index, the end index, the row width in fragments, and the top and bottom boundary indices. While it works, the sequencer reads each fragment's descriptor word through a lookup port. An edge shared with an uncoded neighbour is filtered from the coded side only. The left and top edges of a coded fragment always belong to that fragment, so each fragment gets a fixed edge order.

Top module: `efs_seq`

## Requirements
- R1: A fragment is coded when bit 0 of its descriptor word is set. The other descriptor bits have no effect. An uncoded fragment produces no command and uses exactly one cycle.
- R2: A coded fragment gets a left-edge command only when it is not the first fragment of its row.
- R3: A coded fragment gets a top-edge command only when the start index of its row is strictly greater than the top boundary index.
- R4: A coded fragment gets a right-edge command only when it is not the last fragment of its row and the fragment at index+1 is uncoded.
- R5: A coded fragment gets a bottom-edge command only when index + row width is strictly less than the bottom boundary index and the fragment at index + row width is uncoded.
- R6: Side codes are left=0, top=1, right=2, bottom=3. The commands for one fragment are issued in increasing code order.
- R7: A start with first index >= end index, or with row width <= 1, issues no command and keeps busy low. It raises done in the cycle right after the start edge.
- R8: The rows begin at first, first+width, first+2*width, and so on, while the row start is below the end index. Each row visits all width fragments in ascending index order.
- R9: A command is transferred on a clock edge where valid and ready are both high. Until that edge, valid, fragment and side stay unchanged.
- R10: Busy goes high on the edge that accepts a start and stays high until the final decision. Done is then high for exactly one cycle, and busy is low during that cycle.
- R11: With ready held high, a coded fragment takes 5 cycles and an uncoded fragment takes 1 cycle. Done is therefore visible the sum of these counts after the start edge.
- R12: A start strobe while busy is ignored. The run in progress continues with the parameters it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; the range inputs are captured with it |
| frag_lo_i | input | IDX_W | First fragment index |
| frag_hi_i | input | IDX_W | End index (exclusive bound on row starts) |
| row_w_i | input | IDX_W | Fragments per row |
| top_idx_i | input | IDX_W | Top boundary index |
| bot_idx_i | input | IDX_W | Bottom boundary index |
| lk_idx_o | output | IDX_W | Descriptor lookup index |
| lk_desc_i | input | DESC_W | Descriptor word for lk_idx_o, same cycle |
| cmd_valid_o | output | 1 | Filter command valid |
| cmd_frag_o | output | IDX_W | Fragment index of the command |
| cmd_side_o | output | 2 | Edge side code (R6) |
| cmd_ready_i | input | 1 | Downstream filter accepts the command |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The first decision falls in the cycle after the start edge. Each fragment then takes one decision cycle, plus one cycle per side when ready is held high. With ready tied high, the bench counts clock edges from the start edge to the first cycle in which done is sampled high, and compares that count with the total worked out from the coded pattern. It also checks that done is low one cycle later. A bail-out start must show done right after the start edge. Commands are sampled mid-cycle: a command counts as transferred when valid and ready are both high at that sample. Under random ready stalls, the next sample of a waiting command must show it unchanged.

// File: rtl/efs_pkg.sv
package efs_pkg;

   typedef enum logic [1:0] {
      SIDE_LEFT   = 2'd0,
      SIDE_TOP    = 2'd1,
      SIDE_RIGHT  = 2'd2,
      SIDE_BOTTOM = 2'd3
   } side_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SELF = 2'd1,
      ST_SIDE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/efs_cursor.sv
module efs_cursor #(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [IDX_W-1:0] lo_i,
   input  logic [IDX_W-1:0] hi_i,
   input  logic [IDX_W-1:0] row_w_i,
   output logic [IDX_W-1:0] cur_o,
   output logic [IDX_W-1:0] row_start_o,
   output logic             first_o,
   output logic             last_o,
   output logic             final_o
);
   localparam int SW = IDX_W + 1;

   logic [IDX_W-1:0] cur_q, row_q;
   logic [SW-1:0]    row_next, cur_inc;

   assign row_next = {1'b0, row_q} + {1'b0, row_w_i};
   assign cur_inc  = {1'b0, cur_q} + SW'(1);

   assign first_o     = (cur_q == row_q);
   assign last_o      = (cur_inc == row_next);
   assign final_o     = last_o && (row_next >= {1'b0, hi_i});
   assign cur_o       = cur_q;
   assign row_start_o = row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         row_q <= '0;
      end else if (load_i) begin
         cur_q <= lo_i;
         row_q <= lo_i;
      end else if (step_i) begin
         if (last_o) begin
            row_q <= row_next[IDX_W-1:0];
            cur_q <= row_next[IDX_W-1:0];
         end else begin
            cur_q <= cur_inc[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/efs_edge_rules.sv
module efs_edge_rules
   import efs_pkg::*;
#(
   parameter int IDX_W = 12
) (
   input  side_e            side_i,
   input  logic [IDX_W-1:0] cur_i,
   input  logic [IDX_W-1:0] row_start_i,
   input  logic [IDX_W-1:0] row_w_i,
   input  logic [IDX_W-1:0] top_i,
   input  logic [IDX_W-1:0] bot_i,
   input  logic             first_i,
   input  logic             last_i,
   input  logic             nb_coded_i,
   output logic             want_o
);
   localparam int SW = IDX_W + 1;

   logic [SW-1:0] below_sum;
   assign below_sum = {1'b0, cur_i} + {1'b0, row_w_i};

   always_comb begin
      unique case (side_i)
         SIDE_LEFT:   want_o = !first_i;
         SIDE_TOP:    want_o = (row_start_i > top_i);
         SIDE_RIGHT:  want_o = !last_i && !nb_coded_i;
         SIDE_BOTTOM: want_o = (below_sum < {1'b0, bot_i}) && !nb_coded_i;
         default:     want_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/efs_seq.sv
module efs_seq
   import efs_pkg::*;
#(
   parameter int IDX_W     = 12,
   parameter int DESC_W    = 32,
   parameter int CODED_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  frag_lo_i,
   input  logic [IDX_W-1:0]  frag_hi_i,
   input  logic [IDX_W-1:0]  row_w_i,
   input  logic [IDX_W-1:0]  top_idx_i,
   input  logic [IDX_W-1:0]  bot_idx_i,
   output logic [IDX_W-1:0]  lk_idx_o,
   input  logic [DESC_W-1:0] lk_desc_i,
   output logic              cmd_valid_o,
   output logic [IDX_W-1:0]  cmd_frag_o,
   output logic [1:0]        cmd_side_o,
   input  logic              cmd_ready_i,
   output logic              busy_o,
   output logic              done_o
);
   generate
      if (IDX_W < 2 || DESC_W < 1 || CODED_BIT < 0 || CODED_BIT >= DESC_W) begin : g_bad_cfg
         $error("efs_seq: illegal parameter set");
      end
   endgenerate

   seq_state_e       st_q;
   side_e            side_q;
   logic             done_q;
   logic [IDX_W-1:0] hi_q, w_q, top_q, bot_q;

   logic [IDX_W-1:0] cur, row_start;
   logic             first, last, fin;
   logic             coded, want, bail, load, step, side_adv;

   assign coded = lk_desc_i[CODED_BIT];
   assign bail  = (frag_lo_i >= frag_hi_i) || (row_w_i <= IDX_W'(1));
   assign load  = (st_q == ST_IDLE) && start_i && !bail;
   assign side_adv = (st_q == ST_SIDE) && (!want || cmd_ready_i);
   assign step  = !fin && (((st_q == ST_SELF) && !coded) ||
                           (side_adv && side_q == SIDE_BOTTOM));

   efs_cursor #(.IDX_W(IDX_W)) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .step_i     (step),
      .lo_i       (frag_lo_i),
      .hi_i       (hi_q),
      .row_w_i    (w_q),
      .cur_o      (cur),
      .row_start_o(row_start),
      .first_o    (first),
      .last_o     (last),
      .final_o    (fin)
   );

   efs_edge_rules #(.IDX_W(IDX_W)) u_rules (
      .side_i     (side_q),
      .cur_i      (cur),
      .row_start_i(row_start),
      .row_w_i    (w_q),
      .top_i      (top_q),
      .bot_i      (bot_q),
      .first_i    (first),
      .last_i     (last),
      .nb_coded_i (coded),
      .want_o     (want)
   );

   always_comb begin
      lk_idx_o = cur;
      if (st_q == ST_SIDE) begin
         if (side_q == SIDE_RIGHT)       lk_idx_o = cur + IDX_W'(1);
         else if (side_q == SIDE_BOTTOM) lk_idx_o = cur + w_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         side_q <= SIDE_LEFT;
         done_q <= 1'b0;
         hi_q   <= '0;
         w_q    <= '0;
         top_q  <= '0;
         bot_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  hi_q  <= frag_hi_i;
                  w_q   <= row_w_i;
                  top_q <= top_idx_i;
                  bot_q <= bot_idx_i;
                  if (bail) done_q <= 1'b1;
                  else      st_q   <= ST_SELF;
               end
            end
            ST_SELF: begin
               side_q <= SIDE_LEFT;
               if (coded) begin
                  st_q <= ST_SIDE;
               end else if (fin) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            ST_SIDE: begin
               if (side_adv) begin
                  if (side_q == SIDE_BOTTOM) begin
                     if (fin) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        st_q <= ST_SELF;
                     end
                  end else begin
                     side_q <= side_e'(side_q + 2'd1);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid_o = (st_q == ST_SIDE) && want;
   assign cmd_frag_o  = cur;
   assign cmd_side_o  = side_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
endmodule

// File: rtl/efs_seq_chk.sv
module efs_seq_chk #(
   parameter int IDX_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid_o,
   input logic [IDX_W-1:0] cmd_frag_o,
   input logic [1:0]       cmd_side_o,
   input logic             cmd_ready_i,
   input logic             busy_o,
   input logic             done_o
);
   logic             have_last;
   logic [IDX_W-1:0] last_frag;
   logic [1:0]       last_side;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_frag <= '0;
         last_side <= '0;
      end else if (!busy_o) begin
         have_last <= 1'b0;
      end else if (cmd_valid_o && cmd_ready_i) begin
         have_last <= 1'b1;
         last_frag <= cmd_frag_o;
         last_side <= cmd_side_o;
      end
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_frag_o) && $stable(cmd_side_o)); // R9
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R10
   AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> busy_o); // R10
   AST_SIDE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && have_last && cmd_frag_o == last_frag |-> cmd_side_o > last_side); // R6
   AST_RASTER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && have_last |-> cmd_frag_o >= last_frag); // R8
endmodule

bind efs_seq efs_seq_chk #(.IDX_W(IDX_W)) u_efs_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid_o(cmd_valid_o),
   .cmd_frag_o (cmd_frag_o),
   .cmd_side_o (cmd_side_o),
   .cmd_ready_i(cmd_ready_i),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/efs_seq_bench.sv
module efs_seq_bench;
   localparam int IDX_W  = 12;
   localparam int DESC_W = 32;
   localparam int MEMN   = 64;
   localparam int MAXC   = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [IDX_W-1:0]  frag_lo_i = '0, frag_hi_i = '0, row_w_i = '0;
   logic [IDX_W-1:0]  top_idx_i = '0, bot_idx_i = '0;
   logic [IDX_W-1:0]  lk_idx_o;
   logic [DESC_W-1:0] lk_desc_i;
   logic              cmd_valid_o;
   logic [IDX_W-1:0]  cmd_frag_o;
   logic [1:0]        cmd_side_o;
   logic              cmd_ready_i = 1'b0;
   logic              busy_o, done_o;

   int errors = 0;
   int checks = 0;
   logic [DESC_W-1:0] mem [MEMN];
   logic [31:0] seed = 32'h1234_5678;

   int exp_f [MAXC];
   int exp_s [MAXC];
   int exp_n, exp_t;
   int got_f [MAXC];
   int got_s [MAXC];
   int got_n;

   always #2.5 clk = ~clk;

   assign lk_desc_i = (int'(lk_idx_o) < MEMN) ? mem[lk_idx_o] : '0;

   efs_seq #(.IDX_W(IDX_W), .DESC_W(DESC_W), .CODED_BIT(0)) u_efs_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .frag_lo_i(frag_lo_i), .frag_hi_i(frag_hi_i), .row_w_i(row_w_i),
      .top_idx_i(top_idx_i), .bot_idx_i(bot_idx_i),
      .lk_idx_o(lk_idx_o), .lk_desc_i(lk_desc_i),
      .cmd_valid_o(cmd_valid_o), .cmd_frag_o(cmd_frag_o), .cmd_side_o(cmd_side_o),
      .cmd_ready_i(cmd_ready_i), .busy_o(busy_o), .done_o(done_o)
   );

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   function automatic bit is_coded(int i);
      if (i < 0 || i >= MEMN) return 1'b0;
      return mem[i][0];
   endfunction

   task automatic check(bit ok, string req, int act, int expv, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Expected command list and cycle count derived from the requirements.
   task automatic model(int lo, int hi, int w, int top, int bot);
      exp_n = 0;
      exp_t = 0;
      if (lo >= hi || w <= 1) return;                    // R7
      for (int r = lo; r < hi; r += w) begin             // R8
         for (int f = r; f < r + w; f++) begin
            if (!is_coded(f)) begin exp_t += 1; continue; end   // R1, R11
            exp_t += 5;
            if (f > r)                                   begin exp_f[exp_n] = f; exp_s[exp_n] = 0; exp_n++; end // R2
            if (r > top)                                 begin exp_f[exp_n] = f; exp_s[exp_n] = 1; exp_n++; end // R3
            if (f < r + w - 1 && !is_coded(f + 1))       begin exp_f[exp_n] = f; exp_s[exp_n] = 2; exp_n++; end // R4
            if (f + w < bot && !is_coded(f + w))         begin exp_f[exp_n] = f; exp_s[exp_n] = 3; exp_n++; end // R5
         end
      end
   endtask

   task automatic fill_mem(int kind);
      for (int i = 0; i < MEMN; i++) begin
         logic [31:0] v;
         v = rnd();
         case (kind)
            0: mem[i] = {v[31:1], 1'b1};
            1: mem[i] = {v[31:1], 1'b0};
            default: mem[i] = {v[31:1], v[17]};          // R1: upper bits random
         endcase
      end
   endtask

   task automatic run(int lo, int hi, int w, int top, int bot, bit rnd_ready, bit mid_start, string tag);
      int k;
      bit hold_prev;
      int hold_f, hold_s;
      model(lo, hi, w, top, bot);
      got_n = 0;
      hold_prev = 1'b0;
      hold_f = 0;
      hold_s = 0;
      @(negedge clk);
      frag_lo_i = IDX_W'(lo); frag_hi_i = IDX_W'(hi); row_w_i = IDX_W'(w);
      top_idx_i = IDX_W'(top); bot_idx_i = IDX_W'(bot);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      forever begin
         logic [31:0] v;
         bit rdy;
         if (done_o) break;
         check(busy_o === 1'b1, "R10", int'(busy_o), 1, {tag, " busy during run"});
         if (mid_start && k == 2) begin
            start_i = 1'b1; frag_lo_i = '0; frag_hi_i = IDX_W'(4); row_w_i = IDX_W'(2);
            top_idx_i = '0; bot_idx_i = '0;
         end else if (mid_start && k == 3) begin
            start_i = 1'b0;
         end
         if (hold_prev) begin
            check(cmd_valid_o && int'(cmd_frag_o) == hold_f && int'(cmd_side_o) == hold_s,
                  "R9", int'(cmd_frag_o), hold_f, {tag, " stalled command held"});
         end
         v = rnd();
         rdy = rnd_ready ? v[20] : 1'b1;
         cmd_ready_i = rdy;
         if (cmd_valid_o && rdy && got_n < MAXC) begin
            got_f[got_n] = int'(cmd_frag_o);
            got_s[got_n] = int'(cmd_side_o);
            got_n++;
         end
         hold_prev = cmd_valid_o && !rdy;
         hold_f = int'(cmd_frag_o);
         hold_s = int'(cmd_side_o);
         @(posedge clk);
         k++;
         @(negedge clk);
         if (k > 4000) begin
            check(1'b0, "R10", k, exp_t, {tag, " watchdog on run"});
            break;
         end
      end
      cmd_ready_i = 1'b0;
      check(got_n == exp_n, "R8", got_n, exp_n, {tag, " command count"});
      for (int i = 0; i < got_n && i < exp_n; i++) begin
         check(got_f[i] == exp_f[i], "R8", got_f[i], exp_f[i], {tag, " command fragment"});
         check(got_s[i] == exp_s[i], "R6", got_s[i], exp_s[i], {tag, " command side"});
      end
      if (!rnd_ready)
         check(k == exp_t, (exp_n == 0 && (lo >= hi || w <= 1)) ? "R7" : "R11", k, exp_t, {tag, " cycles to done"});
      @(negedge clk);
      check(done_o == 1'b0 && busy_o == 1'b0, "R10", int'(done_o), 0, {tag, " done one cycle"});
   endtask

   initial begin
      #(150000 * 5);
      errors++;
      checks++;
      $display("FAIL R10 global watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && done_o == 1'b0 && cmd_valid_o == 1'b0, "R10", int'(busy_o), 0, "reset state");
      rst_n = 1'b1;
      @(negedge clk);

      // R7: bail-out starts
      fill_mem(0);
      run(5, 5, 3, 0, 0, 1'b0, 1'b0, "R7 lo==hi");
      run(6, 3, 3, 0, 0, 1'b0, 1'b0, "R7 lo>hi");
      run(0, 8, 1, 0, 0, 1'b0, 1'b0, "R7 w==1");
      run(0, 8, 0, 0, 0, 1'b0, 1'b0, "R7 w==0");

      // R12: start during a run is ignored
      fill_mem(2);
      run(3, 12, 3, 0, 15, 1'b0, 1'b1, "R12 mid start");
      run(3, 12, 3, 0, 15, 1'b1, 1'b1, "R12 mid start stalls");

      // Sweep: R1..R6, R8, R9, R11
      n = 0;
      for (int w = 2; w <= 4; w++)
         for (int nr = 1; nr <= 3; nr++)
            for (int ls = 0; ls < 2; ls++)
               for (int tb = 0; tb < 4; tb++)
                  for (int pk = 0; pk < 4; pk++) begin
                     int lo, hi, top, bot;
                     lo  = ls * w;
                     hi  = lo + nr * w - ((tb >= 2) ? 1 : 0);     // partial last row (R8)
                     top = tb[0] ? 0 : lo;                         // R3
                     bot = (tb == 1) ? hi + w : lo + nr * w;       // R5
                     fill_mem(pk == 0 ? 0 : (pk == 1 ? 1 : 2));
                     run(lo, hi, w, top, bot, n[0], 1'b0, "sweep R2 R3 R4 R5");
                     n++;
                  end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule